// File: doc/BRIEF.md
# Dual-Inverter Redundant State Selector

This block sits inside the space-vector modulator of a drive in which two two-level inverters feed the two ends of an open-end winding. The first inverter runs from a DC link at twice the voltage of the second. Its isolated supply cannot sink charge, so the smaller link capacitor must never be charged by the phase currents. Once per switching period the modulator supplies three nearest vectors, each with a dwell count in clock cycles, and one sample of each phase current. Many vectors can be produced by more than one pair of inverter states. For each vector the block picks the pair whose current into the small capacitor is not positive, using the signs of the currents. The block then plays the three chosen gate patterns in order, each for its dwell.

A vector is given as two signed 3-bit coordinates, the leg-voltage differences A-B and B-C measured in units of the small link voltage. The block forms the candidate state pairs by shifting the common mode of the three leg voltages. Each candidate is rated by the sign of its ideal capacitor current. The best one is applied, so a vector never has to be dropped because of the current direction. Current signs and vectors are captured when the period strobe arrives, so a choice cannot change in the middle of a dwell.

Top module: `redundant_state_sel`

## Requirements
- R1: During and after reset, with no period started, slotOut is the idle code (NUM_SLOTS, 3 by default) and gateOut is 6'b000000.
- R2: gateOut is {A1,B1,C1,A2,B2,C2}, leg bit 1 meaning the upper switch is on. The load leg value is 2*first-bit minus second-bit. For a reachable vector the applied state gives leg differences A-B equal to vecX and B-C equal to vecY of the active slot.
- R3: The ideal capacitor current of a candidate is +i for a second-inverter pattern with one leg high (i of that leg), -i for a pattern with two legs high (i of the low leg), and zero for 000 or 111. Between a +i and a -i candidate, the block picks -i when the sample is above zero and +i otherwise. A sample of exactly zero counts as non-positive.
- R4: When a zero-current candidate exists, it is chosen ahead of any signed one.
- R5: Among equally ranked candidates, the one with the lowest C leg value wins. When no candidate has a non-positive current, the lowest-C candidate is applied anyway.
- R6: A vector that no state pair can produce gives gateOut 6'b000000 for its dwell.
- R7: Current signs and vectors are taken only in the cycle of periodStart. Input changes during the period have no effect on the output.
- R8: After the periodStart edge, slots 0, 1 and 2 appear in order on slotOut, each for its dwell count of cycles. The block then returns to idle.
- R9: A slot with a dwell of zero is skipped. If all dwells are zero, the block stays idle.
- R10: A periodStart that arrives while a period is running, including on its last cycle, discards the running period and starts the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| periodStart | input | 1 | Start of switching period; captures all inputs |
| vecX | input | 3*NUM_SLOTS | Per slot, signed leg difference A-B |
| vecY | input | 3*NUM_SLOTS | Per slot, signed leg difference B-C |
| dwellIn | input | DWELL_W*NUM_SLOTS | Per slot dwell in clock cycles |
| curA | input | CUR_W | Signed phase A current sample |
| curB | input | CUR_W | Signed phase B current sample |
| curC | input | CUR_W | Signed phase C current sample |
| gateOut | output | 6 | Gate pattern of the active slot |
| slotOut | output | 4 | Active slot index, NUM_SLOTS when idle |

## Verification
Two things can land in the same cycle: the end of a running slot sequence and a new period strobe. The same clash occurs earlier in the period, when a strobe cuts into a long dwell. The bench provokes both cases. It raises periodStart on the last cycle of slot 2 and also two cycles into slot 0. It then checks that the following cycles show only the new period's slots and patterns. Throughout, the inputs are changed right after the strobe, so a capture taken at the wrong edge would show up as a wrong pattern.

// File: rtl/rss_pkg.sv
`timescale 1ns/1ps
package rss_pkg;
  localparam int SLOT_FIELD_W = 4;

  typedef struct packed {
    logic                    load;
    logic [SLOT_FIELD_W-1:0] slot;
  } selStrobe_t;

  // Non-positive ideal capacitor current for a second-inverter pattern,
  // given the latched "current above zero" flags {A,B,C}.
  function automatic logic stateGood(input logic [2:0] low, input logic [2:0] pos);
    case ($countones(low))
      1:       return ~|(low & pos);
      2:       return |(~low & pos);
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/rss_ctrl.sv
`timescale 1ns/1ps
module rss_ctrl
  import rss_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int DWELL_W   = 10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         periodStart,
  input  logic [NUM_SLOTS*DWELL_W-1:0] dwellIn,
  output selStrobe_t                   strobe
);
  localparam int DW_TOT = NUM_SLOTS * DWELL_W;
  localparam logic [SLOT_FIELD_W-1:0] IDLE_SLOT = SLOT_FIELD_W'(NUM_SLOTS);

  logic [DW_TOT-1:0]       dwellLat;
  logic [SLOT_FIELD_W-1:0] slot, startSlot, followSlot;
  logic [DWELL_W-1:0]      cnt, startCnt, followCnt;

  function automatic logic [SLOT_FIELD_W-1:0] firstLive(input logic [DW_TOT-1:0] dw, input int from);
    logic [SLOT_FIELD_W-1:0] r;
    r = IDLE_SLOT;
    for (int k = NUM_SLOTS - 1; k >= 0; k--)
      if (k >= from && dw[k*DWELL_W +: DWELL_W] != '0) r = SLOT_FIELD_W'(k);
    return r;
  endfunction

  function automatic logic [DWELL_W-1:0] dwellAt(input logic [DW_TOT-1:0] dw, input logic [SLOT_FIELD_W-1:0] s);
    logic [DWELL_W-1:0] r;
    r = '0;
    for (int k = 0; k < NUM_SLOTS; k++)
      if (s == SLOT_FIELD_W'(k)) r = dw[k*DWELL_W +: DWELL_W];
    return r;
  endfunction

  always_comb begin
    startSlot  = firstLive(dwellIn, 0);
    startCnt   = dwellAt(dwellIn, startSlot);
    followSlot = firstLive(dwellLat, int'(slot) + 1);
    followCnt  = dwellAt(dwellLat, followSlot);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dwellLat <= '0;
      slot     <= IDLE_SLOT;
      cnt      <= '0;
    end else if (periodStart) begin
      dwellLat <= dwellIn;
      slot     <= startSlot;
      cnt      <= startCnt;
    end else if (slot != IDLE_SLOT) begin
      if (cnt == DWELL_W'(1)) begin
        slot <= followSlot;
        cnt  <= followCnt;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign strobe.load = periodStart;
  assign strobe.slot = slot;

  // An active slot always has dwell left to run
  assert_dwell_live_R9: assert property (@(posedge clk) disable iff (!rstN)
    (slot != IDLE_SLOT) |-> (cnt != '0));

  // Slots only move forward within a period
  assert_slot_order_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!periodStart && slot != IDLE_SLOT) |=> (slot >= $past(slot)));

  // Slot index never leaves the legal range
  assert_slot_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    slot <= IDLE_SLOT);
endmodule

// File: rtl/rss_datapath.sv
`timescale 1ns/1ps
module rss_datapath
  import rss_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int CUR_W     = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  selStrobe_t               strobe,
  input  logic [NUM_SLOTS*3-1:0]   vecX,
  input  logic [NUM_SLOTS*3-1:0]   vecY,
  input  logic signed [CUR_W-1:0]  curA,
  input  logic signed [CUR_W-1:0]  curB,
  input  logic signed [CUR_W-1:0]  curC,
  output logic [5:0]               gateOut
);
  localparam int LEG_LEVELS = 4;            // leg values -1..2
  localparam int NUM_SHIFT  = LEG_LEVELS;   // common-mode shifts to try

  logic [2:0] xLat [NUM_SLOTS];
  logic [2:0] yLat [NUM_SLOTS];
  logic [2:0] posLat;                       // {A,B,C} sample above zero

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posLat <= '0;
      for (int k = 0; k < NUM_SLOTS; k++) begin
        xLat[k] <= '0;
        yLat[k] <= '0;
      end
    end else if (strobe.load) begin
      posLat <= {curA > 0, curB > 0, curC > 0};
      for (int k = 0; k < NUM_SLOTS; k++) begin
        xLat[k] <= vecX[k*3 +: 3];
        yLat[k] <= vecY[k*3 +: 3];
      end
    end
  end

  logic              active;
  logic [2:0]        selX, selY;
  logic signed [4:0] xW, yW;

  always_comb begin
    active = 1'b0;
    selX   = '0;
    selY   = '0;
    for (int k = 0; k < NUM_SLOTS; k++)
      if (strobe.slot == SLOT_FIELD_W'(k)) begin
        active = 1'b1;
        selX   = xLat[k];
        selY   = yLat[k];
      end
    xW = {{2{selX[2]}}, selX};
    yW = {{2{selY[2]}}, selY};
  end

  logic [5:0] candSt    [NUM_SHIFT];
  logic       candValid [NUM_SHIFT];
  logic       candZero  [NUM_SHIFT];
  logic       candGood  [NUM_SHIFT];

  for (genvar k = 0; k < NUM_SHIFT; k++) begin : g_shift
    logic signed [4:0] lA, lB, lC;
    logic [2:0] hi, lo;
    assign lC = 5'(k - 1);
    assign lB = lC + yW;
    assign lA = lB + xW;
    assign hi = {lA > 5'sd0, lB > 5'sd0, lC > 5'sd0};
    assign lo = {lA == 5'sd1 || lA == -5'sd1,
                 lB == 5'sd1 || lB == -5'sd1,
                 lC == 5'sd1 || lC == -5'sd1};
    assign candSt[k]    = {hi, lo};
    assign candValid[k] = (lA > -5'sd2) && (lA < 5'sd3) && (lB > -5'sd2) && (lB < 5'sd3);
    assign candZero[k]  = (lo == 3'b000) || (lo == 3'b111);
    assign candGood[k]  = stateGood(lo, posLat);
  end

  logic [5:0] zeroSt, goodSt, anySt;
  logic       zeroHit, goodHit, anyHit;

  always_comb begin
    zeroHit = 1'b0; goodHit = 1'b0; anyHit = 1'b0;
    zeroSt  = '0;   goodSt  = '0;   anySt  = '0;
    for (int k = NUM_SHIFT - 1; k >= 0; k--) begin
      if (candValid[k]) begin
        anyHit = 1'b1;
        anySt  = candSt[k];
        if (candGood[k]) begin goodHit = 1'b1; goodSt = candSt[k]; end
        if (candZero[k]) begin zeroHit = 1'b1; zeroSt = candSt[k]; end
      end
    end
    if (!(active && anyHit)) gateOut = '0;
    else if (zeroHit)        gateOut = zeroSt;
    else if (goodHit)        gateOut = goodSt;
    else                     gateOut = anySt;
  end

  function automatic int legOf(input logic h, input logic l);
    return 2 * int'(h) - int'(l);
  endfunction

  // Applied pattern realises the requested vector
  assert_vector_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    (active && anyHit) |->
      (legOf(gateOut[5], gateOut[2]) - legOf(gateOut[4], gateOut[1]) == int'(xW) &&
       legOf(gateOut[4], gateOut[1]) - legOf(gateOut[3], gateOut[0]) == int'(yW)));

  // If a non-charging pair exists, the applied pair is non-charging
  assert_no_charge_R3: assert property (@(posedge clk) disable iff (!rstN)
    (active && goodHit) |-> stateGood(gateOut[2:0], posLat));

  // Signs are only taken at the period strobe
  assert_signs_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(posLat));
endmodule

// File: rtl/redundant_state_sel.sv
`timescale 1ns/1ps
module redundant_state_sel
  import rss_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int DWELL_W   = 10,
  parameter int CUR_W     = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          periodStart,
  input  logic [NUM_SLOTS*3-1:0]        vecX,
  input  logic [NUM_SLOTS*3-1:0]        vecY,
  input  logic [NUM_SLOTS*DWELL_W-1:0]  dwellIn,
  input  logic signed [CUR_W-1:0]       curA,
  input  logic signed [CUR_W-1:0]       curB,
  input  logic signed [CUR_W-1:0]       curC,
  output logic [5:0]                    gateOut,
  output logic [SLOT_FIELD_W-1:0]       slotOut
);
  selStrobe_t strobe;

  rss_ctrl #(.NUM_SLOTS(NUM_SLOTS), .DWELL_W(DWELL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .periodStart(periodStart),
    .dwellIn(dwellIn), .strobe(strobe)
  );

  rss_datapath #(.NUM_SLOTS(NUM_SLOTS), .CUR_W(CUR_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .vecX(vecX), .vecY(vecY),
    .curA(curA), .curB(curB), .curC(curC),
    .gateOut(gateOut)
  );

  assign slotOut = strobe.slot;
endmodule

// File: tb/redundant_state_sel_bench.sv
`timescale 1ns/1ps
module redundant_state_sel_bench;
  localparam int NS = 3, DW = 10, CW = 12;
  localparam logic [3:0] IDLE = 4'd3;

  logic clk = 1'b0, rstN = 1'b0, periodStart = 1'b0;
  logic [NS*3-1:0] vecX = '0, vecY = '0;
  logic [NS*DW-1:0] dwellIn = '0;
  logic signed [CW-1:0] curA = '0, curB = '0, curC = '0;
  logic [5:0] gateOut;
  logic [3:0] slotOut;

  int checks = 0, errors = 0;
  int xv[3], yv[3], dv[3];
  logic [5:0] expG[3];
  logic       expF[3];

  always #2 clk = ~clk;

  redundant_state_sel u_redundant_state_sel (
    .clk(clk), .rstN(rstN), .periodStart(periodStart),
    .vecX(vecX), .vecY(vecY), .dwellIn(dwellIn),
    .curA(curA), .curB(curB), .curC(curC),
    .gateOut(gateOut), .slotOut(slotOut)
  );

  task automatic check(input string req, input logic [3:0] eSlot, input logic [5:0] eGate);
    checks++;
    if (slotOut !== eSlot || gateOut !== eGate) begin
      errors++;
      $display("FAIL %s: slot=%0d gates=%b expected slot=%0d gates=%b",
               req, slotOut, gateOut, eSlot, eGate);
    end
  endtask

  // Brute force over all 64 state pairs: {found, gates}
  function automatic logic [6:0] model(input int x, input int y, input logic [2:0] pos);
    int zc = 99, gc = 99, ac = 99;
    logic [5:0] zs = '0, gs = '0, as = '0;
    for (int s = 0; s < 64; s++) begin
      logic [5:0] st = 6'(s);
      int dA = 2*int'(st[5]) - int'(st[2]);
      int dB = 2*int'(st[4]) - int'(st[1]);
      int dC = 2*int'(st[3]) - int'(st[0]);
      if (dA - dB == x && dB - dC == y) begin
        logic [2:0] lo = st[2:0];
        int n = $countones(lo);
        logic good;
        if (n == 1)      good = ((lo & pos) == 3'b000);
        else if (n == 2) good = ((~lo & pos) != 3'b000);
        else             good = 1'b1;
        if ((n == 0 || n == 3) && dC < zc) begin zc = dC; zs = st; end
        if (good && dC < gc) begin gc = dC; gs = st; end
        if (dC < ac) begin ac = dC; as = st; end
      end
    end
    if (zc != 99) return {1'b1, zs};
    if (gc != 99) return {1'b1, gs};
    if (ac != 99) return {1'b1, as};
    return 7'b0;
  endfunction

  // Called at a negedge; strobe is taken at the next posedge
  task automatic launch(input int ia, input int ib, input int ic);
    logic [2:0] pos = {ia > 0, ib > 0, ic > 0};
    for (int k = 0; k < 3; k++) begin
      logic [6:0] m = model(xv[k], yv[k], pos);
      vecX[k*3 +: 3] = 3'(xv[k]);
      vecY[k*3 +: 3] = 3'(yv[k]);
      dwellIn[k*DW +: DW] = DW'(dv[k]);
      expF[k] = m[6];
      expG[k] = m[5:0];
    end
    curA = CW'(ia); curB = CW'(ib); curC = CW'(ic);
    periodStart = 1'b1;
    @(negedge clk);
    periodStart = 1'b0;
    // R7: disturb every input after capture
    curA = CW'(-ia); curB = CW'(-ib); curC = CW'(-ic);
    vecX = ~vecX; vecY = vecY ^ 9'b101101101; dwellIn = ~dwellIn;
  endtask

  task automatic verifySlots();
    for (int k = 0; k < 3; k++)
      for (int j = 0; j < dv[k]; j++) begin
        check(expF[k] ? "R2 R3 R4 R5 R7 R8" : "R6", 4'(k), expG[k]);
        @(negedge clk);
      end
    check("R8 R9 idle after period", IDLE, 6'b0);
  endtask

  task automatic setVec(input int k, input int x, input int y, input int d);
    xv[k] = x; yv[k] = y; dv[k] = d;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1 in reset", IDLE, 6'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", IDLE, 6'b0);

    // R3: vector (1,1) has pairs 16' (-ib) and 23' (+ib)
    setVec(0, 1, 1, 1); setVec(1, 1, 1, 0); setVec(2, 1, 1, 0);
    launch(0, 7, 0);
    check("R3 ib>0 picks 16'", 4'd0, 6'b100101);
    @(negedge clk);
    launch(0, -7, 0);
    check("R3 ib<0 picks 23'", 4'd0, 6'b110010);
    @(negedge clk);
    launch(0, 0, 0);
    check("R3 ib==0 picks 23'", 4'd0, 6'b110010);
    @(negedge clk);

    // R4: zero vector prefers zero-current pair with lowest C leg (000,111)
    setVec(0, 0, 0, 1);
    launch(7, -7, 0);
    check("R4 zero vector", 4'd0, 6'b000111);
    @(negedge clk);

    // R5: only pair for (3,0) is 100/011 (-ia); ia<0 still applied
    setVec(0, 3, 0, 1);
    launch(-7, 7, 0);
    check("R5 fixed-sign pair applied", 4'd0, 6'b100011);
    @(negedge clk);

    // R6: unreachable vector
    setVec(0, 3, 3, 2);
    launch(7, 7, 7);
    check("R6 unreachable", 4'd0, 6'b000000);
    @(negedge clk);
    check("R6 unreachable held", 4'd0, 6'b000000);
    @(negedge clk);

    // R9: zero dwells skipped
    setVec(0, 1, 0, 0); setVec(1, 0, 1, 2); setVec(2, -1, 0, 0);
    launch(7, 0, -7);
    verifySlots();
    setVec(0, 1, 0, 0); setVec(1, 0, 1, 0); setVec(2, -1, 0, 0);
    launch(7, 0, -7);
    check("R9 all dwells zero", IDLE, 6'b0);
    @(negedge clk);

    // R10: restart in the middle of slot 0
    setVec(0, 2, -1, 5); setVec(1, 1, 1, 5); setVec(2, 0, -2, 5);
    launch(7, -7, 0);
    check("R10 first period slot0", 4'd0, expG[0]);
    @(negedge clk);
    check("R10 first period slot0", 4'd0, expG[0]);
    @(negedge clk);
    setVec(0, -1, 2, 1); setVec(1, 1, 1, 2); setVec(2, 2, 0, 1);
    launch(0, 7, -7);
    verifySlots();

    // R10: strobe on the last cycle of slot 2
    setVec(0, 1, -1, 1); setVec(1, -2, 1, 1); setVec(2, 0, 2, 1);
    launch(-7, -7, 7);
    check("R10 old slot0", 4'd0, expG[0]);
    @(negedge clk);
    check("R10 old slot1", 4'd1, expG[1]);
    @(negedge clk);
    check("R10 old slot2", 4'd2, expG[2]);
    setVec(0, 2, 1, 1); setVec(1, -3, 2, 1); setVec(2, 1, 1, 2);
    launch(7, 0, 7);
    verifySlots();

    // Sweep: every coordinate pair under every sign/zero current pattern
    for (int v = 0; v < 49; v++)
      for (int cc = 0; cc < 27; cc++) begin
        int cur[3];
        int tmp = cc;
        for (int p = 0; p < 3; p++) begin
          cur[p] = (tmp % 3 == 0) ? 7 : (tmp % 3 == 1) ? 0 : -7;
          tmp = tmp / 3;
        end
        setVec(0, v / 7 - 3, v % 7 - 3, 1);
        setVec(1, ((v + 17) % 49) / 7 - 3, ((v + 17) % 49) % 7 - 3, 1 + cc % 3);
        setVec(2, ((v + 33) % 49) / 7 - 3, ((v + 33) % 49) % 7 - 3, 1);
        launch(cur[0], cur[1], cur[2]);
        verifySlots();
      end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule